// File: doc/BRIEF.md
# Wrapping Sequential Read Address Generator

This block produces the byte address for a streaming read out of a paged memory. Every page, and every staging buffer, holds a fixed number of bytes that need not be a power of two (1056 by default). An address is a page number and a byte offset. A load pulse captures a start page, a start offset and a wrap mode. After that, each advance pulse moves the address on by one byte. The read datapath beside it uses the address for memory access and output shifting.

There are three wrap modes. In the first, the whole array is streamed: the offset carries into the next page, and after the last byte of the last page the address goes back to page 0. In the second, the read loops inside the page that was loaded. In the third, the read loops inside a staging buffer, and the page number has no meaning. Every wrap takes place on the same advance that passes the last byte, so the stream has no gap cycles.

Top module: `rd_addr_gen`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `page_o` and `ofs_o` are 0 and the mode is whole-array.
- R2: A load (`load_i`=1) makes `page_o` equal to `start_page_i` and `ofs_o` equal to `start_ofs_i` on the next clock edge, and latches `mode_i`. The mode codes are: 2'b00 whole-array, 2'b01 page loop, 2'b10 buffer loop, 2'b11 page loop.
- R3: A load with `start_ofs_i` at or above PAGE_BYTES sets `ofs_o` to PAGE_BYTES-1. The next advance then goes to offset 0.
- R4: When `load_i` and `adv_i` are high in the same cycle, only the load takes effect.
- R5: An advance at an offset below PAGE_BYTES-1 increments `ofs_o` by one and leaves `page_o` unchanged. `ofs_o` never reaches PAGE_BYTES.
- R6: With both `load_i` and `adv_i` low, `page_o` and `ofs_o` hold their values.
- R7: In whole-array mode, an advance at offset PAGE_BYTES-1 gives offset 0 of the next page on the same edge.
- R8: In whole-array mode, an advance at offset PAGE_BYTES-1 of page NUM_PAGES-1 gives page 0, offset 0.
- R9: In page-loop mode (code 2'b01 or 2'b11), an advance at offset PAGE_BYTES-1 gives offset 0 of the same page.
- R10: In buffer-loop mode (2'b10), `page_o` is 0 from the load onward, and an advance at offset PAGE_BYTES-1 gives offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the start address and mode |
| mode_i | input | 2 | Wrap mode, sampled on load |
| start_page_i | input | PAGE_W | Start page number |
| start_ofs_i | input | OFS_W | Start byte offset |
| adv_i | input | 1 | Advance by one byte |
| page_o | output | PAGE_W | Current page |
| ofs_o | output | OFS_W | Current byte offset |

## Verification
Every result is registered. A load or an advance driven before a clock edge shows on `page_o` and `ofs_o` just after that edge, and that includes the page carry and both wraps. The bench drives its inputs on the falling edge and compares one time unit after the next rising edge, against a model that it updates arithmetically for that same edge. A reduced configuration, with 12-byte pages and 6 pages, lets the sweeps cover every offset of every page, every clamped start offset and both array wraps.

// File: rtl/rag_pkg.sv
package rag_pkg;
  typedef enum logic [1:0] {
    RAG_ARRAY = 2'b00,
    RAG_PAGE  = 2'b01,
    RAG_BUF   = 2'b10,
    RAG_PAGE2 = 2'b11
  } rag_mode_e;
endpackage

// File: rtl/rag_clamp.sv
module rag_clamp #(
  parameter int PAGE_BYTES = 1056,
  parameter int OFS_W      = 11
) (
  input  logic [OFS_W-1:0] ofs_i,
  output logic [OFS_W-1:0] ofs_o
);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(PAGE_BYTES - 1);

  generate
    if (PAGE_BYTES == (1 << OFS_W)) begin : g_pow2
      assign ofs_o = ofs_i;
    end else begin : g_cmp
      assign ofs_o = (ofs_i > LAST) ? LAST : ofs_i;
    end
  endgenerate
endmodule

// File: rtl/rag_ofs_ctr.sv
module rag_ofs_ctr #(
  parameter int PAGE_BYTES = 1056,
  parameter int OFS_W      = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OFS_W-1:0] start_i,
  input  logic             step_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic             wrap_o
);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(PAGE_BYTES - 1);

  logic at_end;
  assign at_end = (ofs_o == LAST);
  assign wrap_o = step_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ofs_o <= '0;
    else if (load_i) ofs_o <= start_i;
    else if (step_i) ofs_o <= at_end ? '0 : ofs_o + OFS_W'(1);
  end
endmodule

// File: rtl/rag_page_ctr.sv
module rag_page_ctr #(
  parameter int NUM_PAGES = 16384,
  parameter int PAGE_W    = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] start_i,
  input  logic              inc_i,
  output logic [PAGE_W-1:0] page_o
);
  localparam logic [PAGE_W-1:0] LAST_PG = PAGE_W'(NUM_PAGES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     page_o <= '0;
    else if (load_i) page_o <= start_i;
    else if (inc_i)  page_o <= (page_o == LAST_PG) ? '0 : page_o + PAGE_W'(1);
  end
endmodule

// File: rtl/rd_addr_gen.sv
module rd_addr_gen #(
  parameter int PAGE_BYTES = 1056,
  parameter int PAGE_W     = 14,
  parameter int NUM_PAGES  = 1 << PAGE_W,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        mode_i,
  input  logic [PAGE_W-1:0] start_page_i,
  input  logic [OFS_W-1:0]  start_ofs_i,
  input  logic              adv_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFS_W-1:0]  ofs_o
);
  import rag_pkg::*;

  rag_mode_e         mode_q;
  logic [OFS_W-1:0]  ofs_start;
  logic [PAGE_W-1:0] page_start;
  logic              step, ofs_wrap, page_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= RAG_ARRAY;
    else if (load_i) mode_q <= rag_mode_e'(mode_i);
  end

  // load wins over advance
  assign step       = adv_i & ~load_i;
  assign page_start = (rag_mode_e'(mode_i) == RAG_BUF) ? '0 : start_page_i;
  assign page_inc   = ofs_wrap & (mode_q == RAG_ARRAY);

  rag_clamp #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_clamp (
    .ofs_i(start_ofs_i),
    .ofs_o(ofs_start)
  );

  rag_ofs_ctr #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_ofs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .start_i(ofs_start),
    .step_i (step),
    .ofs_o  (ofs_o),
    .wrap_o (ofs_wrap)
  );

  rag_page_ctr #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .start_i(page_start),
    .inc_i  (page_inc),
    .page_o (page_o)
  );
endmodule

// File: rtl/rag_chk.sv
module rag_chk #(
  parameter int PAGE_BYTES = 1056,
  parameter int PAGE_W     = 14,
  parameter int NUM_PAGES  = 1 << PAGE_W,
  parameter int OFS_W      = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [1:0]        mode_i,
  input logic [PAGE_W-1:0] start_page_i,
  input logic [OFS_W-1:0]  start_ofs_i,
  input logic              adv_i,
  input logic [PAGE_W-1:0] page_o,
  input logic [OFS_W-1:0]  ofs_o,
  input logic [1:0]        mode_q
);
  localparam logic [OFS_W-1:0]  LAST    = OFS_W'(PAGE_BYTES - 1);
  localparam logic [PAGE_W-1:0] LAST_PG = PAGE_W'(NUM_PAGES - 1);

  logic at_last;
  assign at_last = (ofs_o == LAST);

  p_ofs_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_o <= LAST);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && start_ofs_i <= LAST && mode_i != 2'b10) |=>
      (ofs_o == $past(start_ofs_i) && page_o == $past(start_page_i)));

  p_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && start_ofs_i > LAST) |=> ofs_o == LAST);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> ($stable(page_o) && $stable(ofs_o)));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && !at_last) |=>
      (ofs_o == $past(ofs_o) + OFS_W'(1) && $stable(page_o)));

  p_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && at_last && mode_q == 2'b00) |=>
      (ofs_o == '0 && page_o == (($past(page_o) == LAST_PG) ? '0 : $past(page_o) + PAGE_W'(1))));

  p_loop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && at_last && mode_q != 2'b00) |=>
      (ofs_o == '0 && $stable(page_o)));

  p_buf_page_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b10) |-> page_o == '0);
endmodule

bind rd_addr_gen rag_chk #(
  .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .NUM_PAGES(NUM_PAGES), .OFS_W(OFS_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .mode_i(mode_i),
  .start_page_i(start_page_i), .start_ofs_i(start_ofs_i), .adv_i(adv_i),
  .page_o(page_o), .ofs_o(ofs_o), .mode_q(mode_q)
);

// File: tb/sim_rd_addr_gen.sv
`timescale 1ns/1ps
module sim_rd_addr_gen;
  localparam int PB    = 12;
  localparam int PW    = 3;
  localparam int NP    = 6;
  localparam int OW    = $clog2(PB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0, adv = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [PW-1:0] sp = '0;
  logic [OW-1:0] so = '0;
  logic [PW-1:0] page;
  logic [OW-1:0] ofs;

  int n_chk = 0, n_fail = 0;
  int e_page = 0, e_ofs = 0, e_mode = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rd_addr_gen #(.PAGE_BYTES(PB), .PAGE_W(PW), .NUM_PAGES(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .mode_i(mode),
    .start_page_i(sp), .start_ofs_i(so), .adv_i(adv),
    .page_o(page), .ofs_o(ofs)
  );

  task automatic check(string req);
    n_chk++;
    if (int'(page) != e_page || int'(ofs) != e_ofs) begin
      n_fail++;
      $display("FAIL %s: page/ofs actual %0d/%0d expected %0d/%0d",
               req, page, ofs, e_page, e_ofs);
    end
  endtask

  task automatic cyc(bit l, int m, int p, int o, bit a, string req);
    @(negedge clk);
    load = l; mode = 2'(m); sp = PW'(p); so = OW'(o); adv = a;
    @(posedge clk);
    #1;
    if (l) begin
      e_mode = m;
      e_ofs  = (o >= PB) ? PB - 1 : o;
      e_page = (m == 2) ? 0 : p;
    end else if (a) begin
      if (e_ofs == PB - 1) begin
        e_ofs = 0;
        if (e_mode == 0) e_page = (e_page + 1) % NP;
      end else e_ofs++;
    end
    check(req);
  endtask

  initial begin
    #3;
    check("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1");

    // R7 R8: full array sweep from 0, twice around
    cyc(1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 2 * NP * PB + 3; i++) cyc(0, 0, 0, 0, 1, "R7/R8");
    // R8 directly from last byte
    cyc(1, 0, NP - 1, PB - 1, 0, "R2");
    cyc(0, 0, 0, 0, 1, "R8");

    // R9: page loop, both codes, every page
    for (int m = 1; m <= 3; m += 2)
      for (int p = 0; p < NP; p++) begin
        cyc(1, m, p, 5, 0, "R2");
        for (int i = 0; i < PB + 4; i++) cyc(0, 0, 0, 0, 1, "R9");
      end

    // R10: buffer loop, page forced to 0
    cyc(1, 2, 4, 3, 0, "R10");
    for (int i = 0; i < 2 * PB; i++) cyc(0, 0, 0, 0, 1, "R10");

    // R3: every start offset incl. out of range, in each mode
    for (int m = 0; m < 3; m++)
      for (int o = 0; o < (1 << OW); o++) begin
        cyc(1, m, 2, o, 0, "R3");
        cyc(0, 0, 0, 0, 1, "R3");
      end

    // R4: load with advance in same cycle
    cyc(1, 0, 1, 4, 1, "R4");
    cyc(1, 1, 3, 15, 1, "R4");
    cyc(0, 0, 0, 0, 1, "R4");

    // R6 / R5: idle cycles mixed with advances
    cyc(1, 0, 2, 9, 0, "R2");
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, bit'((i % 3) == 0), "R5/R6");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule